// File: doc/BRIEF.md
# Static LCD Three-and-a-Half Digit Segment Driver

This block turns a signed converter reading into the drive signals for a static (non-multiplexed) liquid crystal display. The display has three full seven-segment digits (hundreds, tens, units), a leading half digit that can show only blank or "1", and a minus-sign segment. The reading arrives as an 11-bit magnitude with a polarity bit and an overrange flag, qualified by a one-cycle valid strobe.

A sequential shift-and-add-3 unit converts the magnitude to decimal, and the decoded pattern is held in a pending register. It is copied to the display register only on a backplane edge, so the glass never sees a digit change in the middle of a backplane half period. The backplane is a 50% square wave. Each segment output carries the backplane level when the segment is off and the inverted level when it is on, so every segment averages zero DC against the backplane.

Top module: `lcd_static_driver`

## Requirements
- R1: `bp` is a square wave that holds each level for exactly HALF_PERIOD clock cycles. After reset it first toggles on the HALF_PERIOD-th active edge.
- R2: Every segment output equals `bp` while its segment is off and equals the inverse of `bp` while its segment is on.
- R3: Segment outputs change only in the cycle in which `bp` toggles. New display content takes effect only at a backplane toggle.
- R4: Digit patterns use bit 0 = segment a through bit 6 = segment g, with on-patterns 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F, 9=0x6F.
- R5: A magnitude of 0 to 1999 is shown in decimal. The half digit is lit when the magnitude is 1000 or more. The three full digits are never blanked for leading zeros.
- R6: The minus segment is lit exactly when the captured polarity bit is 1, and this includes a magnitude of zero.
- R7: When the overrange flag is set, or the magnitude exceeds 1999, the half digit is lit, all three full digits are blank, and the minus segment follows the polarity.
- R8: A strobe is accepted only when the converter is idle. The reading is loaded into the pending register on the 12th edge after the accepting edge. The converter is busy for those 12 cycles, and strobes during them are ignored. The display shows the pending content from the first backplane toggle after that load.
- R9: While `rst_n` is low at a clock edge, `bp`, all segment outputs and the stored display are cleared to 0, and the display is blank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_valid | input | 1 | One-cycle strobe: a new reading is present |
| rd_mag | input | 11 | Reading magnitude in counts |
| rd_neg | input | 1 | Reading polarity, 1 = negative |
| rd_over | input | 1 | Converter overrange flag |
| bp | output | 1 | Backplane drive |
| seg_units | output | 7 | Units digit segments a..g (bit 0 = a) |
| seg_tens | output | 7 | Tens digit segments a..g |
| seg_hund | output | 7 | Hundreds digit segments a..g |
| seg_thou | output | 1 | Half digit, drives segments b and c together |
| seg_minus | output | 1 | Minus sign segment |

## Verification
A behavioural model in the bench predicts the backplane, the pending reading and the displayed reading on every clock. Every output is compared against it on each cycle. The readings tried are positive and negative zero, single-digit values, full-scale 1999, the 1000 and 999 boundaries, a range overflow at 2000 and 2047, and an explicit overrange flag. Between them they separate polarity handling at null, the half-digit threshold, the digit encodings and blanking. Strobes are placed at varied offsets from the backplane edges, including one inside the busy window, to test acceptance and the rule that updates wait for an edge.

// File: rtl/lcd_pkg.sv
// Shared types and the digit encoding for the static LCD driver.
// Assumes segment order bit0 = a ... bit6 = g.
package lcd_pkg;

    localparam int SEG_W = 7;

    typedef logic [SEG_W-1:0] seg7_t;

    // Content of the display as on/off bits, independent of backplane phase.
    typedef struct packed {
        logic  minus;
        logic  thou;
        seg7_t hund;
        seg7_t tens;
        seg7_t units;
    } disp_t;

    localparam int DISP_W = $bits(disp_t);

    // Map one decimal digit to its lit segments; non-decimal codes are blank.
    function automatic seg7_t digit_to_seg(input logic [3:0] d);
        case (d)
            4'd0:    digit_to_seg = 7'h3F;
            4'd1:    digit_to_seg = 7'h06;
            4'd2:    digit_to_seg = 7'h5B;
            4'd3:    digit_to_seg = 7'h4F;
            4'd4:    digit_to_seg = 7'h66;
            4'd5:    digit_to_seg = 7'h6D;
            4'd6:    digit_to_seg = 7'h7D;
            4'd7:    digit_to_seg = 7'h07;
            4'd8:    digit_to_seg = 7'h7F;
            4'd9:    digit_to_seg = 7'h6F;
            default: digit_to_seg = 7'h00;
        endcase
    endfunction

endpackage

// File: rtl/lcd_bp_gen.sv
// Backplane generator: divides the clock into a 50% square wave.
// Assumes HALF_PERIOD >= 2. The tick output pulses in the cycle whose
// closing edge toggles bp.
module lcd_bp_gen #(
    parameter int HALF_PERIOD = 400
) (
    input  logic clk,
    input  logic rst_n,
    output logic bp,
    output logic tick
);
    localparam int CW = (HALF_PERIOD > 2) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    // Count cycles within a half period and flip the backplane at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            bp  <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            bp  <= ~bp;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/lcd_bin2bcd.sv
// Sequential binary-to-BCD converter using shift-and-add-3.
// Takes IN_W shift cycles plus one result cycle. start is honoured only
// when idle; busy covers every non-idle cycle and done is the last one.
module lcd_bin2bcd #(
    parameter int IN_W   = 11,
    parameter int DIGITS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [IN_W-1:0]       bin,
    output logic                  busy,
    output logic                  done,
    output logic [4*DIGITS-1:0]   bcd
);
    localparam int SH_W = 4 * DIGITS + IN_W;
    localparam int SW   = (IN_W > 2) ? $clog2(IN_W) : 1;
    localparam logic [SW-1:0] LAST_STEP = SW'(IN_W - 1);

    typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_DONE} cstate_t;

    cstate_t         state;
    logic [SW-1:0]   step;
    logic [SH_W-1:0] sh;
    logic [SH_W-1:0] adj;

    assign adj[IN_W-1:0] = sh[IN_W-1:0];

    generate
        for (genvar d = 0; d < DIGITS; d++) begin : g_adj
            // Add 3 to any decimal column of 5 or more before the next shift.
            always_comb begin
                if (sh[IN_W + 4*d +: 4] >= 4'd5)
                    adj[IN_W + 4*d +: 4] = sh[IN_W + 4*d +: 4] + 4'd3;
                else
                    adj[IN_W + 4*d +: 4] = sh[IN_W + 4*d +: 4];
            end
        end
    endgenerate

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_DONE);
    assign bcd  = sh[SH_W-1 -: 4*DIGITS];

    // Sequence load, IN_W adjusted shifts, then one result cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            step  <= '0;
            sh    <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    sh    <= {{(4*DIGITS){1'b0}}, bin};
                    step  <= '0;
                    state <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    sh   <= {adj[SH_W-2:0], 1'b0};
                    step <= step + 1'b1;
                    if (step == LAST_STEP)
                        state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lcd_digit_map.sv
// Maps BCD digits, polarity and overrange to display on/off bits.
// Assumes the top decimal digit is 0 or 1. Overrange lights only the
// half digit and blanks the full digits. Polarity is always shown.
module lcd_digit_map
    import lcd_pkg::*;
#(
    parameter int FULL_DIGITS = 3
) (
    input  logic [4*(FULL_DIGITS+1)-1:0] bcd,
    input  logic                         neg,
    input  logic                         over,
    output disp_t                        disp
);
    seg7_t full [FULL_DIGITS];

    generate
        for (genvar i = 0; i < FULL_DIGITS; i++) begin : g_dig
            // Decode one full digit, blanked on overrange.
            always_comb full[i] = over ? '0 : digit_to_seg(bcd[4*i +: 4]);
        end
    endgenerate

    // Assemble the display word.
    always_comb begin
        disp.units = full[0];
        disp.tens  = full[1];
        disp.hund  = full[2];
        disp.thou  = over | (bcd[4*FULL_DIGITS +: 4] != 4'd0);
        disp.minus = neg;
    end

endmodule

// File: rtl/lcd_static_driver.sv
// Static LCD driver for a signed three-and-a-half digit reading.
// Captures a reading on rd_valid when idle, converts it to decimal,
// and moves the result to the display only on a backplane toggle.
// Segment outputs are the backplane XOR the on/off bit.
module lcd_static_driver
    import lcd_pkg::*;
#(
    parameter int HALF_PERIOD = 400,
    parameter int MAG_W       = 11,
    parameter int MAX_MAG     = 1999
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_valid,
    input  logic [MAG_W-1:0] rd_mag,
    input  logic             rd_neg,
    input  logic             rd_over,
    output logic             bp,
    output logic [6:0]       seg_units,
    output logic [6:0]       seg_tens,
    output logic [6:0]       seg_hund,
    output logic             seg_thou,
    output logic             seg_minus
);
    localparam int FULL_DIGITS = 3;
    localparam int BCD_W       = 4 * (FULL_DIGITS + 1);

    logic             tick;
    logic             conv_busy;
    logic             conv_done;
    logic             start;
    logic [BCD_W-1:0] bcd;
    logic             neg_q;
    logic             over_q;
    disp_t            decoded;
    disp_t            pending;
    disp_t            shown;

    assign start = rd_valid & ~conv_busy;

    lcd_bp_gen #(.HALF_PERIOD(HALF_PERIOD)) u_bp (
        .clk   (clk),
        .rst_n (rst_n),
        .bp    (bp),
        .tick  (tick)
    );

    lcd_bin2bcd #(.IN_W(MAG_W), .DIGITS(FULL_DIGITS + 1)) u_conv (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .bin   (rd_mag),
        .busy  (conv_busy),
        .done  (conv_done),
        .bcd   (bcd)
    );

    lcd_digit_map #(.FULL_DIGITS(FULL_DIGITS)) u_map (
        .bcd  (bcd),
        .neg  (neg_q),
        .over (over_q),
        .disp (decoded)
    );

    // Hold polarity and effective overrange of the reading being converted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_q  <= 1'b0;
            over_q <= 1'b0;
        end else if (start) begin
            neg_q  <= rd_neg;
            over_q <= rd_over | (rd_mag > MAG_W'(MAX_MAG));
        end
    end

    // Store a finished conversion until the next backplane edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         pending <= '0;
        else if (conv_done) pending <= decoded;
    end

    // Update displayed content only together with the backplane toggle.
    always_ff @(posedge clk) begin
        if (!rst_n)    shown <= '0;
        else if (tick) shown <= pending;
    end

    // Drive each segment in or out of phase with the backplane.
    always_comb begin
        seg_units = shown.units ^ {7{bp}};
        seg_tens  = shown.tens  ^ {7{bp}};
        seg_hund  = shown.hund  ^ {7{bp}};
        seg_thou  = shown.thou  ^ bp;
        seg_minus = shown.minus ^ bp;
    end

endmodule

// File: rtl/lcd_static_driver_chk.sv
// Property checker for lcd_static_driver, attached by bind.
// Watches the pins plus the converter busy flag.
module lcd_static_driver_chk #(
    parameter int MAG_W = 11
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bp,
    input logic [6:0] seg_units,
    input logic [6:0] seg_tens,
    input logic [6:0] seg_hund,
    input logic       seg_thou,
    input logic       seg_minus,
    input logic       conv_busy
);
    localparam int RW = $clog2(MAG_W + 3) + 1;

    logic [RW-1:0] busy_run;
    logic [6:0]    units_on;

    assign units_on = seg_units ^ {7{bp}};

    function automatic logic legal_digit(input logic [6:0] p);
        legal_digit = (p == 7'h00) || (p == 7'h3F) || (p == 7'h06) ||
                      (p == 7'h5B) || (p == 7'h4F) || (p == 7'h66) ||
                      (p == 7'h6D) || (p == 7'h7D) || (p == 7'h07) ||
                      (p == 7'h7F) || (p == 7'h6F);
    endfunction

    // Count consecutive busy cycles of the converter.
    always_ff @(posedge clk) begin
        if (!rst_n)         busy_run <= '0;
        else if (conv_busy) busy_run <= busy_run + 1'b1;
        else                busy_run <= '0;
    end

    // R1: a level that has just started is held for the next cycle too.
    p_bp_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bp != $past(bp)) |=> $stable(bp));

    // R3: segments stay put while the backplane does.
    p_seg_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bp == $past(bp)) |-> ($stable(seg_units) && $stable(seg_tens) &&
                               $stable(seg_hund) && $stable(seg_thou) &&
                               $stable(seg_minus)));

    // R4: the units digit only ever shows a legal pattern or blank.
    p_digit_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        legal_digit(units_on));

    // R8: one conversion keeps the converter busy for at most MAG_W+1 cycles.
    p_conv_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= RW'(MAG_W + 1));

    // R9: a reset edge leaves the backplane and all segments low.
    p_reset_blank_r9: assert property (@(posedge clk)
        !rst_n |=> (!bp && seg_units == 7'h00 && seg_tens == 7'h00 &&
                    seg_hund == 7'h00 && !seg_thou && !seg_minus));

endmodule

bind lcd_static_driver lcd_static_driver_chk #(.MAG_W(MAG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bp        (bp),
    .seg_units (seg_units),
    .seg_tens  (seg_tens),
    .seg_hund  (seg_hund),
    .seg_thou  (seg_thou),
    .seg_minus (seg_minus),
    .conv_busy (conv_busy)
);

// File: tb/lcd_static_driver_bench.sv
// Bench for lcd_static_driver: a behavioural model predicts every output
// on every clock, and directed checks cover the boundary readings.
module lcd_static_driver_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 40;
    localparam int LAT        = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_valid = 1'b0;
    logic [10:0] rd_mag = '0;
    logic        rd_neg = 1'b0;
    logic        rd_over = 1'b0;
    logic        bp;
    logic [6:0]  seg_units, seg_tens, seg_hund;
    logic        seg_thou, seg_minus;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_static_driver #(.HALF_PERIOD(HALF)) u_lcd_static_driver (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_mag(rd_mag),
        .rd_neg(rd_neg), .rd_over(rd_over), .bp(bp),
        .seg_units(seg_units), .seg_tens(seg_tens), .seg_hund(seg_hund),
        .seg_thou(seg_thou), .seg_minus(seg_minus)
    );

    function automatic logic [6:0] pat(input int d);
        case (d)
            0: pat = 7'h3F; 1: pat = 7'h06; 2: pat = 7'h5B; 3: pat = 7'h4F;
            4: pat = 7'h66; 5: pat = 7'h6D; 6: pat = 7'h7D; 7: pat = 7'h07;
            8: pat = 7'h7F; default: pat = 7'h6F;
        endcase
    endfunction

    // Expected on/off bits {minus, thou, hund, tens, units}.
    function automatic logic [22:0] expect_bits(input int m, input bit n, input bit o);
        if (o || m > 1999) expect_bits = {n, 1'b1, 21'h0};
        else expect_bits = {n, (m >= 1000), pat((m / 100) % 10),
                            pat((m / 10) % 10), pat(m % 10)};
    endfunction

    // Reference model state.
    bit          m_bp = 0;
    int          m_cnt = 0;
    int          m_left = 0;
    logic [22:0] m_disp = '0, m_pend = '0, m_val = '0;
    bit          m_live = 0;

    always @(posedge clk) begin
        m_live = 1;
        if (!rst_n) begin
            m_bp = 0; m_cnt = 0; m_left = 0; m_disp = '0; m_pend = '0;
        end else begin
            if (m_cnt == HALF - 1) begin
                m_bp = ~m_bp; m_cnt = 0; m_disp = m_pend;
            end else m_cnt++;
            if (m_left > 0) begin
                m_left--;
                if (m_left == 0) m_pend = m_val;
            end else if (rd_valid) begin
                m_val  = expect_bits(int'(rd_mag), rd_neg, rd_over);
                m_left = LAT;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output with the model each cycle.
    always @(negedge clk) begin
        if (m_live && !finished) begin
            logic [22:0] e;
            e = m_disp ^ {23{m_bp}};
            check(bp === m_bp, "R1 backplane", int'(bp), int'(m_bp));
            check({seg_hund, seg_tens, seg_units} === e[20:0], "R2 R3 R5 digits",
                  int'({seg_hund, seg_tens, seg_units}), int'(e[20:0]));
            check(seg_thou === e[21], "R5 R7 half digit", int'(seg_thou), int'(e[21]));
            check(seg_minus === e[22], "R6 minus", int'(seg_minus), int'(e[22]));
        end
    end

    task automatic strobe(input int m, input bit n, input bit o);
        @(negedge clk);
        rd_valid = 1'b1; rd_mag = 11'(m); rd_neg = n; rd_over = o;
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    task automatic show(input int m, input bit n, input bit o, input int skew);
        strobe(m, n, o);
        repeat (2 * HALF + LAT + 4 + skew) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R9: reset clears everything.
        check(!bp && seg_units == 0 && seg_tens == 0 && seg_hund == 0 &&
              !seg_thou && !seg_minus, "R9 reset", int'(seg_units), 0);
        rst_n = 1'b1;

        // R1: measure a half period.
        begin
            int n = 0;
            logic b0;
            @(negedge clk); b0 = bp;
            while (bp == b0) @(negedge clk);
            b0 = bp;
            while (bp == b0) begin @(negedge clk); n++; end
            check(n == HALF, "R1 half period", n, HALF);
        end

        show(0, 0, 0, 3);
        check(seg_minus == bp, "R6 positive zero minus off", int'(seg_minus), int'(bp));
        show(0, 1, 0, 7);
        check(seg_minus == !bp, "R6 negative zero minus on", int'(seg_minus), int'(!bp));
        check((seg_units ^ {7{bp}}) == 7'h3F, "R5 zero not blanked",
              int'(seg_units ^ {7{bp}}), 'h3F);
        show(1234, 1, 0, 11);
        check((seg_units ^ {7{bp}}) == 7'h66, "R4 digit 4", int'(seg_units ^ {7{bp}}), 'h66);
        check(seg_tens == (7'h4F ^ {7{bp}}), "R2 tens phase", int'(seg_tens), int'(7'h4F ^ {7{bp}}));
        show(7, 0, 0, 19);
        check((seg_units ^ {7{bp}}) == 7'h07, "R4 digit 7", int'(seg_units ^ {7{bp}}), 'h07);
        show(1999, 0, 0, 23);
        check(seg_thou == !bp && (seg_hund ^ {7{bp}}) == 7'h6F, "R5 full scale",
              int'(seg_hund ^ {7{bp}}), 'h6F);
        show(999, 1, 0, 29);
        check(seg_thou == bp, "R2 R5 half digit off at 999", int'(seg_thou), int'(bp));
        show(1000, 0, 0, 31);
        check(seg_thou == !bp, "R5 half digit on at 1000", int'(seg_thou), int'(!bp));
        show(2000, 0, 0, 37);
        check(seg_thou == !bp && seg_hund == {7{bp}}, "R7 range overflow",
              int'(seg_hund ^ {7{bp}}), 0);
        show(5, 1, 1, 41);
        check(seg_units == {7{bp}} && seg_minus == !bp, "R7 flag blanks",
              int'(seg_units ^ {7{bp}}), 0);
        show(2047, 0, 0, 2);
        check(seg_tens == {7{bp}}, "R7 max code", int'(seg_tens ^ {7{bp}}), 0);

        // R8: a second strobe inside the busy window is ignored.
        strobe(321, 0, 0);
        strobe(888, 1, 0);
        repeat (2 * HALF + LAT + 4) @(negedge clk);
        check((seg_units ^ {7{bp}}) == 7'h06 && seg_minus == bp, "R8 busy strobe ignored",
              int'(seg_units ^ {7{bp}}), 'h06);

        // R3: strobe just before a toggle, display waits for a later edge.
        show(8, 0, 0, 0);
        check((seg_units ^ {7{bp}}) == 7'h7F, "R3 R8 late strobe", int'(seg_units ^ {7{bp}}), 'h7F);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule